// File: doc/BRIEF.md
# Request/Clear-to-Send Grant Sequencer

This block sits on the modem side of a serial link and answers a terminal that wants to transmit. When the terminal asks to send and has declared itself ready, the sequencer turns on the outgoing carrier. It holds the grant back for a programmable settling time, counted in system clock cycles, and only then grants clear-to-send. When the request goes away, the carrier goes off first. The grant is withdrawn a programmable number of cycles later. If the request disappears while the carrier is still settling, the attempt is abandoned and no grant is ever issued.

The block also drives data-set-ready ON from the first clock after reset and keeps it there. It reports carrier-detect by passing a received-carrier input through a short synchronizer. A strap input lets the local data-set-ready stand in for a terminal that has no request line. All line-facing control signals are active-low: 0 means ON, 1 means OFF. The carrier enable is active-low as well. Typical half-duplex turnaround is 100 to 200 ms, and the default parameters give a settle time of 20 ms at 100 MHz.

Top module: `rts_cts_sequencer`

## Requirements
- R1: While reset is held, carrierN, ctsN, dsrN and dcdN all read 1 (OFF). After reset, with no request, carrierN and ctsN stay 1.
- R2: An effective request turns the carrier on (carrierN=0) on the first clock edge after it is sampled. ctsN is still 1 at that point.
- R3: ctsN goes to 0 exactly SETTLE_CYCLES clock cycles after carrierN went to 0, and it stays 0 while the request holds.
- R4: Once the request is withdrawn during a grant, carrierN returns to 1 on the next edge. ctsN stays 0 for exactly RELEASE_CYCLES further cycles and then returns to 1.
- R5: If the request is withdrawn while the carrier is settling, carrierN returns to 1 on the next edge and ctsN never goes to 0 for that attempt.
- R6: dsrN is 0 from the first clock edge after reset onward.
- R7: With the terminal-ready input dtrN at 1, a request is treated as absent. No attempt starts, and dropping dtrN to 1 during a grant runs the normal release of R4.
- R8: With loopEn=1, rtsN is ignored and the request is taken from the local data-set-ready (still gated by dtrN).
- R9: dcdN equals the inverse of rxCarrier delayed by DCD_SYNC clock cycles.
- R10: A request that returns during the release interval does not shorten it. ctsN still returns to 1 after RELEASE_CYCLES cycles, and carrierN goes to 0 again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active-low |
| dtrN | input | 1 | Terminal-ready from the terminal, 0 = ON |
| rtsN | input | 1 | Request-to-send from the terminal, 0 = ON |
| loopEn | input | 1 | 1 = take the request from local data-set-ready instead of rtsN |
| rxCarrier | input | 1 | Raw received-carrier indication, 1 = carrier present |
| carrierN | output | 1 | Outgoing carrier enable, 0 = carrier on |
| ctsN | output | 1 | Clear-to-send to the terminal, 0 = ON |
| dsrN | output | 1 | Data-set-ready to the terminal, 0 = ON |
| dcdN | output | 1 | Carrier-detect to the terminal, 0 = ON |

## Verification
The bench builds the sequencer with SETTLE_CYCLES=5, RELEASE_CYCLES=3 and DCD_SYNC=2. These values are small enough to sweep several cases in full:

- every abort point inside the settle window;
- every re-request point inside the release window;
- several hold lengths of the grant.

Each expected edge is placed by counting cycles from the stimulus. The small synchronizer depth lets a twelve-bit carrier pattern be compared against its delayed inverse cycle by cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_GRANT,
    ST_RELEASE
  } seqState_e;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } seqStrobe_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int SETTLE_CYCLES  = 2_000_000,
  parameter int RELEASE_CYCLES = 500_000,
  parameter int DCD_SYNC       = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       rxCarrier,
  output logic       settleDone,
  output logic       releaseDone,
  output logic       dsrN,
  output logic       dcdN
);

  localparam int MAX_CYCLES = (SETTLE_CYCLES > RELEASE_CYCLES) ? SETTLE_CYCLES : RELEASE_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYCLES + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST  = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] RELEASE_LAST = CNT_W'(RELEASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_TOP      = CNT_W'(MAX_CYCLES - 1);

  logic [CNT_W-1:0]    cnt;
  logic                dsrReg;
  logic [DCD_SYNC-1:0] dcdPipe;

  // Shared interval counter: settle and release never overlap.
  always_ff @(posedge clk) begin
    if (!rstN)             cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntInc) cnt <= cnt + 1'b1;
  end

  assign settleDone  = (cnt == SETTLE_LAST);
  assign releaseDone = (cnt == RELEASE_LAST);

  // Data-set-ready: OFF in reset, ON from the first edge after it.
  always_ff @(posedge clk) begin
    if (!rstN) dsrReg <= 1'b1;
    else       dsrReg <= 1'b0;
  end
  assign dsrN = dsrReg;

  // Received-carrier synchronizer, depth chosen by parameter.
  for (genvar g = 0; g < DCD_SYNC; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) dcdPipe[0] <= 1'b0;
        else       dcdPipe[0] <= rxCarrier;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) dcdPipe[g] <= 1'b0;
        else       dcdPipe[g] <= dcdPipe[g-1];
      end
    end
  end
  assign dcdN = ~dcdPipe[DCD_SYNC-1];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_TOP); // R3
  AST_DSR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> !dsrN); // R6
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> (cnt == '0)); // R4

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqOn,
  input  logic       settleDone,
  input  logic       releaseDone,
  output seqStrobe_t strobe,
  output logic       carrierN,
  output logic       ctsN
);

  seqState_e state;
  seqState_e stateNext;

  always_comb begin
    stateNext     = state;
    strobe.cntClr = 1'b0;
    strobe.cntInc = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqOn) begin
          stateNext     = ST_SETTLE;
          strobe.cntClr = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (!reqOn) begin
          stateNext     = ST_IDLE;
          strobe.cntClr = 1'b1;
        end else if (settleDone) begin
          stateNext     = ST_GRANT;
          strobe.cntClr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_GRANT: begin
        if (!reqOn) begin
          stateNext     = ST_RELEASE;
          strobe.cntClr = 1'b1;
        end
      end
      ST_RELEASE: begin
        if (releaseDone) begin
          stateNext     = ST_IDLE;
          strobe.cntClr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign carrierN = !((state == ST_SETTLE) || (state == ST_GRANT));
  assign ctsN     = !((state == ST_GRANT) || (state == ST_RELEASE));

  AST_CARRIER_BEFORE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctsN) |-> (!carrierN && !$past(carrierN))); // R2
  AST_GRANT_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctsN) |-> ($past(state) == ST_SETTLE && $past(settleDone))); // R3
  AST_DROP_BEFORE_REVOKE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctsN) |-> (carrierN && $past(carrierN))); // R4
  AST_ABORT_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETTLE && !reqOn) |=> (ctsN && carrierN)); // R5
  AST_NO_GRANT_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (!reqOn && ctsN) |=> ctsN); // R7

endmodule

// File: rtl/rts_cts_sequencer.sv
module rts_cts_sequencer
  import seq_pkg::*;
#(
  parameter int SETTLE_CYCLES  = 2_000_000,
  parameter int RELEASE_CYCLES = 500_000,
  parameter int DCD_SYNC       = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dtrN,
  input  logic rtsN,
  input  logic loopEn,
  input  logic rxCarrier,
  output logic carrierN,
  output logic ctsN,
  output logic dsrN,
  output logic dcdN
);

  seqStrobe_t strobe;
  logic       settleDone;
  logic       releaseDone;
  logic       reqOn;

  // Request is valid only with terminal ready; loopback takes it from local DSR.
  assign reqOn = !dtrN && (loopEn ? !dsrN : !rtsN);

  seq_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .reqOn       (reqOn),
    .settleDone  (settleDone),
    .releaseDone (releaseDone),
    .strobe      (strobe),
    .carrierN    (carrierN),
    .ctsN        (ctsN)
  );

  seq_datapath #(
    .SETTLE_CYCLES  (SETTLE_CYCLES),
    .RELEASE_CYCLES (RELEASE_CYCLES),
    .DCD_SYNC       (DCD_SYNC)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rxCarrier   (rxCarrier),
    .settleDone  (settleDone),
    .releaseDone (releaseDone),
    .dsrN        (dsrN),
    .dcdN        (dcdN)
  );

  AST_LOOP_IGNORES_RTS: assert property (@(posedge clk) disable iff (!rstN)
    (loopEn && $past(loopEn) && !dtrN && $past(!dtrN) && !$past(ctsN) && !$past(carrierN))
      |-> (!ctsN && !carrierN)); // R8

endmodule

// File: tb/tb_rts_cts_sequencer.sv
module tb_rts_cts_sequencer;

  localparam int S = 5;
  localparam int R = 3;
  localparam int D = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dtrN = 1'b1;
  logic rtsN = 1'b1;
  logic loopEn = 1'b0;
  logic rxCarrier = 1'b0;
  logic carrierN, ctsN, dsrN, dcdN;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rts_cts_sequencer #(
    .SETTLE_CYCLES  (S),
    .RELEASE_CYCLES (R),
    .DCD_SYNC       (D)
  ) dut (
    .clk       (clk),
    .rstN      (rstN),
    .dtrN      (dtrN),
    .rtsN      (rtsN),
    .loopEn    (loopEn),
    .rxCarrier (rxCarrier),
    .carrierN  (carrierN),
    .ctsN      (ctsN),
    .dsrN      (dsrN),
    .dcdN      (dcdN)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Request just became effective at this negedge: carrier on, grant after S cycles.
  task automatic raiseAndWait();
    for (int n = 1; n <= S + 1; n++) begin
      @(negedge clk);
      chk("R2 carrier on during settle/grant", carrierN, 1'b0);
      chk("R3 cts timing after carrier", ctsN, (n <= S) ? 1'b1 : 1'b0);
    end
  endtask

  // Request just withdrawn at this negedge: carrier off, cts held R cycles.
  task automatic dropAndWait();
    for (int n = 1; n <= R + 1; n++) begin
      @(negedge clk);
      chk("R4 carrier off after withdraw", carrierN, 1'b1);
      chk("R4 cts held during release", ctsN, (n <= R) ? 1'b0 : 1'b1);
    end
  endtask

  task automatic idleCheck(input string tag, input int cycles);
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      chk(tag, ctsN, 1'b1);
      chk(tag, carrierN, 1'b1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] pat;
    logic [11:0] hist;
    pat  = 12'b1011_0010_1110;
    hist = '0;

    // R1: reset values
    repeat (3) @(negedge clk);
    chk("R1 carrierN in reset", carrierN, 1'b1);
    chk("R1 ctsN in reset", ctsN, 1'b1);
    chk("R1 dsrN in reset", dsrN, 1'b1);
    chk("R1 dcdN in reset", dcdN, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R6 dsr on after reset", dsrN, 1'b0);
    idleCheck("R1 idle after reset", 2);

    // R7: terminal not ready blocks the request
    rtsN = 1'b0;
    idleCheck("R7 no attempt without dtr", S + 3);
    rtsN = 1'b1;
    dtrN = 1'b0;
    @(negedge clk);

    // R2/R3/R4: normal grants, hold length swept
    for (int h = 0; h < 4; h++) begin
      rtsN = 1'b0;
      raiseAndWait();
      for (int k = 0; k < h; k++) begin
        @(negedge clk);
        chk("R3 cts held while requested", ctsN, 1'b0);
      end
      rtsN = 1'b1;
      dropAndWait();
      idleCheck("R4 idle after release", 1);
    end

    // R5: abort at every settle position
    for (int a = 1; a <= S; a++) begin
      rtsN = 1'b0;
      for (int n = 1; n <= a; n++) begin
        @(negedge clk);
        chk("R5 settling carrier on", carrierN, 1'b0);
        chk("R5 settling cts off", ctsN, 1'b1);
      end
      rtsN = 1'b1;
      idleCheck("R5 aborted attempt never grants", S + R + 2);
    end

    // R10: re-request at every release position
    for (int j = 1; j <= R; j++) begin
      rtsN = 1'b0;
      raiseAndWait();
      rtsN = 1'b1;
      for (int n = 1; n <= R + 1; n++) begin
        @(negedge clk);
        chk("R10 carrier off in release", carrierN, 1'b1);
        chk("R10 release not shortened", ctsN, (n <= R) ? 1'b0 : 1'b1);
        if (n == j) rtsN = 1'b0;
      end
      @(negedge clk);
      chk("R10 carrier back after release", carrierN, 1'b0);
      chk("R10 cts off at restart", ctsN, 1'b1);
      rtsN = 1'b1;
      idleCheck("R10 abort restart", S + 2);
    end

    // R7: dtr dropped during grant runs the release
    rtsN = 1'b0;
    raiseAndWait();
    dtrN = 1'b1;
    dropAndWait();
    rtsN = 1'b1;
    dtrN = 1'b0;
    idleCheck("R7 idle after dtr release", 2);

    // R8: loopback takes request from DSR, rts ignored
    loopEn = 1'b1;
    raiseAndWait();
    for (int k = 0; k < 4; k++) begin
      rtsN = k[0];
      @(negedge clk);
      chk("R8 rts ignored in loopback (cts)", ctsN, 1'b0);
      chk("R8 rts ignored in loopback (carrier)", carrierN, 1'b0);
    end
    rtsN = 1'b1;
    dtrN = 1'b1;
    dropAndWait();
    loopEn = 1'b0;
    dtrN = 1'b0;
    idleCheck("R8 idle after loopback", 2);

    // R9: carrier detect pipeline
    for (int i = 0; i < 12 + D; i++) begin
      @(negedge clk);
      if (i >= D) chk("R9 dcd delayed inverse", dcdN, ~hist[i-D]);
      if (i < 12) begin
        rxCarrier = pat[i];
        hist[i] = pat[i];
      end
    end

    chk("R6 dsr still on", dsrN, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule